// File: doc/BRIEF.md
# Dual-strobe presettable up/down counter

This block is a small binary counter that steps up on a rising edge of one strobe and down on a rising edge of a second strobe. A step is taken only while the strobe that is not moving rests high. A fast system clock samples both strobes through synchronizers and finds their rising edges. The counter wraps in both directions.

An active-high clear and an active-low preset act on the count output straight away, through a combinational override in front of the count register. Clear wins over preset. Two active-low terminal flags, carry at the top value and borrow at zero, copy the level of their own strobe. Those flags can therefore act as the strobes of a following stage. A rising edge that arrives while the other strobe is low is treated as a misuse: the count holds and a fault flag pulses for one system clock.

The control pins are plain levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_strobe` while `dn_strobe` is high raises the count by one. It shows on `count_q` no later than SYNC_STAGES+1 system clocks after the edge (3 with the default of 2).
- R2: A rising edge on `dn_strobe` while `up_strobe` is high lowers the count by one, with the same latency as R1.
- R3: The count wraps modulo 2^WIDTH: one step up from 15 gives 0, and one step down from 0 gives 15 (WIDTH=4).
- R4: While `clear` is high, `count_q` reads 0 in the same cycle, whatever `load_n`, `load_data` and the strobes do. Strobe edges seen during clear are not counted, and the count stays 0 after release.
- R5: While `load_n` is low and `clear` is low, `count_q` equals `load_data` in the same cycle, whatever the strobes do. After release, the count continues from the last loaded value. Strobe edges seen during the load are not counted and raise no fault.
- R6: `carry_n` equals `up_strobe` while `count_q` is 15, and is 1 at every other count. The flag follows the strobe combinationally, with no system-clock delay.
- R7: `borrow_n` equals `dn_strobe` while `count_q` is 0, and is 1 at every other count. The flag follows the strobe combinationally.
- R8: A strobe that is low through a clear or a load and stays low after release is counted normally on its next rising edge.
- R9: Three cases are a fault: a rising edge on one strobe while the other is low, or rising edges on both strobes in the same sample. In a fault the count holds and `dir_fault` is high for exactly one system clock. No fault is flagged during clear or load.
- R10: After reset, `count_q` is 0 and `dir_fault` is 0. With both strobes high, `carry_n` and `borrow_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset of the sampling and count registers |
| up_strobe | input | 1 | Count-up strobe; a rising edge steps up |
| dn_strobe | input | 1 | Count-down strobe; a rising edge steps down |
| clear | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low preset enable |
| load_data | input | WIDTH | Preset value |
| count_q | output | WIDTH | Current count, including the override |
| carry_n | output | 1 | Active-low carry, copies `up_strobe` at the top count |
| borrow_n | output | 1 | Active-low borrow, copies `dn_strobe` at zero |
| dir_fault | output | 1 | One-clock pulse on a misused strobe edge |

## Verification
A wrong synchronizer history would show up in two ways: a lost or duplicated step on `count_q`, or a spurious `dir_fault` pulse. Either appears within three system clocks of the strobe edge that exposed it. A fault in the override path or in the wrap arithmetic shows on `count_q` in the same cycle as the clear or load, or at the 15/0 boundary of the sweep. A wrong terminal decode appears at once as a carry or borrow level that disagrees with its strobe.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  // Decision taken by the count core for one system-clock sample
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_FAULT = 2'd3
  } step_e;

  // Index of each strobe lane in the synchronizer array
  localparam int unsigned LANE_UP = 0;
  localparam int unsigned LANE_DN = 1;
  localparam int unsigned LANES   = 2;

endpackage

// File: rtl/ucnt_strobe_sync.sv
module ucnt_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic level_q,
  output logic rise_q
);

  // Strobes idle high, so every flop resets to one: no false edge at start
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic [STAGES:0]   chain_in;

  assign chain_in = {chain_q, strobe_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_in[STAGES-1:0];
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_q = chain_q[STAGES-1];
  assign rise_q  = level_q & ~prev_q;

  // A detected rise lasts one sample only
  a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

endmodule

// File: rtl/ucnt_count_core.sv
module ucnt_count_core
  import ucnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_data,
  input  logic             up_lvl,
  input  logic             up_rise,
  input  logic             dn_lvl,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] view_q,
  output logic             fault_q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  step_e step;
  logic  override;

  assign override = clear | ~load_n;

  always_comb begin
    if (up_rise && dn_rise) begin
      step = STEP_FAULT;
    end else if (up_rise) begin
      step = dn_lvl ? STEP_UP : STEP_FAULT;
    end else if (dn_rise) begin
      step = up_lvl ? STEP_DOWN : STEP_FAULT;
    end else begin
      step = STEP_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= ~override & (step == STEP_FAULT);
      if (clear) begin
        state_q <= '0;
      end else if (!load_n) begin
        state_q <= load_data;
      end else begin
        case (step)
          STEP_UP:   state_q <= state_q + ONE;
          STEP_DOWN: state_q <= state_q - ONE;
          default:   state_q <= state_q;
        endcase
      end
    end
  end

  // Override path in front of the register: clear first, then load
  always_comb begin
    if (clear) begin
      view_q = '0;
    end else if (!load_n) begin
      view_q = load_data;
    end else begin
      view_q = state_q;
    end
  end

  a_r4_clear_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> state_q == '0);

  a_r5_load_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> state_q == $past(load_data));

  a_r9_fault_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> state_q == $past(state_q));

  a_r9_fault_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> !fault_q);

  a_r4_no_fault_in_override: assert property (@(posedge clk) disable iff (!rst_n)
    override |=> !fault_q);

endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
  import ucnt_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             dir_fault
);

  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  logic [LANES-1:0] strobe_raw;
  logic [LANES-1:0] strobe_lvl;
  logic [LANES-1:0] strobe_rise;
  logic [WIDTH-1:0] state_q;

  assign strobe_raw[LANE_UP] = up_strobe;
  assign strobe_raw[LANE_DN] = dn_strobe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ucnt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_in(strobe_raw[g]),
      .level_q  (strobe_lvl[g]),
      .rise_q   (strobe_rise[g])
    );
  end

  ucnt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load_n   (load_n),
    .load_data(load_data),
    .up_lvl   (strobe_lvl[LANE_UP]),
    .up_rise  (strobe_rise[LANE_UP]),
    .dn_lvl   (strobe_lvl[LANE_DN]),
    .dn_rise  (strobe_rise[LANE_DN]),
    .state_q  (state_q),
    .view_q   (count_q),
    .fault_q  (dir_fault)
  );

  // Terminal flags gate the raw strobe so that a next stage sees its waveform
  assign carry_n  = ~((count_q == TOP_VAL) & ~up_strobe);
  assign borrow_n = ~((count_q == '0) & ~dn_strobe);

  a_r6_carry_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != TOP_VAL) |-> carry_n);

  a_r7_borrow_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) |-> borrow_n);

  a_r6_carry_low_needs_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> !up_strobe);

  a_r7_borrow_low_needs_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> !dn_strobe);

  a_r3_step_is_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && !$past(clear) && $past(load_n))
      |-> (state_q == $past(state_q) || state_q == $past(state_q) + WIDTH'(1)
           || state_q == $past(state_q) - WIDTH'(1)));

endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_strobe = 1'b1;
  logic         dn_strobe = 1'b1;
  logic         clear = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] load_data = '0;
  logic [W-1:0] count_q;
  logic         carry_n;
  logic         borrow_n;
  logic         dir_fault;

  always #5 clk = ~clk;

  updn_strobe_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_strobe(up_strobe), .dn_strobe(dn_strobe),
    .clear(clear), .load_n(load_n), .load_data(load_data),
    .count_q(count_q), .carry_n(carry_n), .borrow_n(borrow_n), .dir_fault(dir_fault)
  );

  int n_checks = 0;
  int n_errs   = 0;
  int fault_seen = 0;
  int exp_faults = 0;
  int model = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && dir_fault) fault_seen++;

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int shown();
    if (clear) return 0;
    if (!load_n) return int'(load_data);
    return model;
  endfunction

  task automatic check_all(input string tag);
    int q;
    q = shown();
    check_val({tag, " count R1 R2 R3"}, int'(count_q), q);
    check_val({tag, " carry R6"}, int'(carry_n), (q == 15) ? int'(up_strobe) : 1);
    check_val({tag, " borrow R7"}, int'(borrow_n), (q == 0) ? int'(dn_strobe) : 1);
    check_val({tag, " fault R9"}, fault_seen, exp_faults);
  endtask

  // Drive both strobes, update the model from the rules, then settle and check
  task automatic set_strobes(input logic u, input logic d, input string tag);
    bit ru, rd, ovr;
    @(negedge clk);
    ru = u && !up_strobe;
    rd = d && !dn_strobe;
    ovr = clear || !load_n;
    up_strobe = u;
    dn_strobe = d;
    #1;
    // terminal flags follow the strobe before any count change
    check_val({tag, " immediate carry R6"}, int'(carry_n), (shown() == 15) ? int'(u) : 1);
    check_val({tag, " immediate borrow R7"}, int'(borrow_n), (shown() == 0) ? int'(d) : 1);
    if (!ovr) begin
      if (ru && rd) exp_faults++;
      else if (ru) begin if (d) model = (model + 1) % 16; else exp_faults++; end
      else if (rd) begin if (u) model = (model + 15) % 16; else exp_faults++; end
    end
    repeat (6) @(negedge clk);
    check_all(tag);
  endtask

  task automatic pulse_up(input string tag);
    set_strobes(1'b0, dn_strobe, tag);
    set_strobes(1'b1, dn_strobe, tag);
  endtask

  task automatic pulse_dn(input string tag);
    set_strobes(up_strobe, 1'b0, tag);
    set_strobes(up_strobe, 1'b1, tag);
  endtask

  task automatic do_load(input int v, input string tag);
    @(negedge clk);
    load_data = W'(v);
    load_n = 1'b0;
    #1;
    check_val({tag, " load shows at once R5"}, int'(count_q), clear ? 0 : v);
    if (!clear) model = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_load();
    @(negedge clk);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk);
    clear = 1'b1;
    #1;
    check_val({tag, " clear shows at once R4"}, int'(count_q), 0);
    model = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_clear();
    @(negedge clk);
    clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check_val("R10 reset count", int'(count_q), 0);
    check_val("R10 reset carry", int'(carry_n), 1);
    check_val("R10 reset borrow", int'(borrow_n), 1);
    check_val("R10 reset fault", int'(dir_fault), 0);

    // Scripted sequence: clear, load 13, up to 2, down to 13
    do_clear("seq");
    end_clear();
    do_load(13, "seq");
    end_load();
    check_all("seq loaded R5");
    for (int i = 0; i < 5; i++) pulse_up("seq up R1 R3 R6");
    check_val("seq reached 2 R3", int'(count_q), 2);
    for (int i = 0; i < 5; i++) pulse_dn("seq down R2 R3 R7");
    check_val("seq back to 13 R3", int'(count_q), 13);

    // Sweep every preset value with up/down round trips
    for (int v = 0; v < 16; v++) begin
      do_load(v, "sweep");
      end_load();
      pulse_up("sweep up R1");
      pulse_dn("sweep down R2");
      pulse_dn("sweep down R2");
      pulse_up("sweep up R1");
      check_val("sweep round trip R3", int'(count_q), v);
    end

    // Full wrap up and down from zero
    do_clear("wrap");
    end_clear();
    for (int i = 0; i < 17; i++) pulse_up("wrap up R3");
    for (int i = 0; i < 18; i++) pulse_dn("wrap down R3");

    // R9 faults: up edge with down low, then a valid down edge restores level
    do_load(6, "fault");
    end_load();
    set_strobes(1'b1, 1'b0, "fault dn falls R9");
    set_strobes(1'b0, 1'b0, "fault up falls R9");
    set_strobes(1'b1, 1'b0, "fault up rise with dn low R9");
    set_strobes(1'b1, 1'b1, "fault dn rise counts R2");
    set_strobes(1'b0, 1'b1, "fault prep R9");
    set_strobes(1'b0, 1'b0, "fault prep R9");
    set_strobes(1'b1, 1'b1, "fault both rise R9");
    set_strobes(1'b1, 1'b0, "fault prep2 R9");
    set_strobes(1'b0, 1'b0, "fault prep2 R9");
    set_strobes(1'b0, 1'b1, "fault dn rise with up low R9");
    set_strobes(1'b1, 1'b1, "fault up rise counts R1");

    // R8: strobe low through clear, first rise after release counts
    set_strobes(1'b0, 1'b1, "R8 up low");
    do_clear("R8");
    end_clear();
    set_strobes(1'b1, 1'b1, "R8 first rise after clear");
    check_val("R8 count after clear", int'(count_q), 1);
    set_strobes(1'b1, 1'b0, "R8 dn low");
    do_load(9, "R8");
    end_load();
    set_strobes(1'b1, 1'b1, "R8 first rise after load");
    check_val("R8 count after load", int'(count_q), 8);

    // R5: edge inside a load is not counted and raises no fault
    set_strobes(1'b0, 1'b1, "R5 up low");
    do_load(5, "R5");
    set_strobes(1'b1, 1'b1, "R5 rise during load");
    set_strobes(1'b1, 1'b0, "R5 dn falls during load");
    set_strobes(1'b0, 1'b0, "R5 up falls during load");
    set_strobes(1'b1, 1'b0, "R5 misuse during load");
    set_strobes(1'b1, 1'b1, "R5 dn rise during load");
    end_load();
    check_all("R5 after load");
    pulse_up("R5 up after load R1");
    check_val("R5 continues from load", int'(count_q), 6);

    // R4: clear beats load, edges ignored during clear
    do_load(11, "R4");
    do_clear("R4 clear over load");
    set_strobes(1'b0, 1'b1, "R4 strobe in clear");
    set_strobes(1'b1, 1'b1, "R4 rise in clear");
    end_clear();
    check_val("R4 load still held", int'(count_q), 11);
    end_load();
    model = 11;
    check_all("R4 after release");
    do_clear("R4 plain");
    pulse_up("R4 up in clear");
    end_clear();
    check_all("R4 stays zero");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule